// File: doc/BRIEF.md
# Input Capture Timer with Reload

This block is a 16-bit up-counter with an input-capture function. It advances once per prescaled tick of the system clock. The prescaler divides by a power of two from 1 to 128. When the count equals a programmable reload value on a tick, the counter goes back to 0001h and keeps running. A chosen edge of an external timer pin is first brought into the clock domain by a two-flop synchronizer. That edge copies the present count into a capture register, and the counter does not stop or restart.

Capture and reload events share a single interrupt line, which pulses for one cycle. A status flag tells the two events apart: a capture sets it and a reload clears it. Software programs the block through a byte-wide register bus while the timer is disabled, then enables it. It can also clear the capture register to 0000h. A capture register that still reads 0000h after an interrupt means that interrupt came from a reload. Software reads the 16-bit count and capture values high byte first. That read freezes the low byte in a holding register, so the two bytes always belong to the same 16-bit value.

Register map (addr): 0 control (bit 7 enable, bit 6 edge select with 0 = rising and 1 = falling, bits 2:0 prescale exponent n, divide by 2^n), 1 status (bit 0 capture flag), 2/3 count high/low, 4/5 reload high/low, 6/7 capture high/low. Unused control bits read as 0.

Top module: `cap_timer`

## Requirements
- R1: After reset every register reads 00h and irq is low.
- R2: While enabled, the count advances by one every 2^n system clocks, where n is control bits 2:0. The prescaler restarts from zero on enable. While disabled, the count holds unless software writes it.
- R3: On a tick with count equal to reload, the next count is 0001h, irq pulses and the status flag (status bit 0) clears.
- R4: While enabled, the selected edge of tmr_in (control bit 6: 0 rising, 1 falling) is seen after a two-flop synchronizer. It copies the count of that cycle into the capture register, sets the status flag and pulses irq. The counter keeps advancing.
- R5: An edge of the non-selected polarity, and any edge while disabled, leaves capture, status and irq unchanged.
- R6: When a capture and a reload fall in the same cycle, the capture register takes the count from before the wrap, the status flag ends set, and irq pulses once.
- R7: A read strobe on a high-byte address (2 or 6) returns that high byte and latches the matching low byte into a holding register. Reads of address 3 or 7 return the holding register.
- R8: Writes to the status register are ignored. Count, reload and capture bytes are writable. A capture register cleared to 0000h still reads 0000h after a reload-only interrupt.
- R9: irq is high for exactly the one cycle after each cycle with a capture or reload event, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (drives the holding registers) |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational on addr) |
| tmr_in | input | 1 | External timer input pin, asynchronous |
| irq | output | 1 | Shared capture/reload interrupt pulse |

## Verification
The counter is run at divide-by-1 and divide-by-16, each over a known window. The counts reached show the prescale ratio and the restart of the prescaler on enable. Captures are tried with rising and with falling selection, each followed by the opposite edge and by edges while disabled, to separate correct polarity from plain edge sensitivity. A wrap over a short reload span and a capture timed onto the exact wrap cycle show that the flag clears on reload and that capture wins a tie. High-then-low reads on both a halted and a running counter show whether the low byte comes from the holding register or from the live count.

// File: rtl/cap_timer_pkg.sv
package cap_timer_pkg;
  localparam int ADDR_W = 3;
  localparam int BYTE_W = 8;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL  = 3'd0,
    A_STAT  = 3'd1,
    A_CNT_H = 3'd2,
    A_CNT_L = 3'd3,
    A_RLD_H = 3'd4,
    A_RLD_L = 3'd5,
    A_CAP_H = 3'd6,
    A_CAP_L = 3'd7
  } reg_addr_e;

  localparam int EN_BIT  = 7;
  localparam int POL_BIT = 6;
endpackage

// File: rtl/cap_timer_sync_edge.sv
module cap_timer_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic fall_sel_i,
  output logic edge_o
);
  logic [STAGES:0] sh_q;
  logic [STAGES:0] sh_d;
  logic            now_lvl;
  logic            prev_lvl;

  always_comb begin
    sh_d = {sh_q[STAGES-1:0], pin_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign now_lvl  = sh_q[STAGES-1];
  assign prev_lvl = sh_q[STAGES];
  assign edge_o   = fall_sel_i ? (prev_lvl & ~now_lvl) : (now_lvl & ~prev_lvl);
endmodule

// File: rtl/cap_timer_prescale.sv
module cap_timer_prescale #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int PCNT_W = (1 << SEL_W) - 1;

  logic [PCNT_W-1:0] pcnt_q;
  logic [PCNT_W-1:0] pcnt_d;
  logic [PCNT_W-1:0] mask;

  always_comb begin
    mask   = (PCNT_W'(1) << sel_i) - PCNT_W'(1);
    pcnt_d = run_i ? pcnt_q + PCNT_W'(1) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end

  assign tick_o = run_i && ((pcnt_q & mask) == mask);
endmodule

// File: rtl/cap_timer_core.sv
module cap_timer_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             cap_evt_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic             cnt_wr_hi_i,
  input  logic             cnt_wr_lo_i,
  input  logic             cap_wr_hi_i,
  input  logic             cap_wr_lo_i,
  input  logic [7:0]       wdata_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] capture_o,
  output logic             flag_o,
  output logic             irq_o,
  output logic             reload_evt_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] cap_q, cap_d;
  logic             flag_q, flag_d;
  logic             irq_q, irq_d;
  logic             hit;

  assign hit = tick_i && (cnt_q == reload_i);

  always_comb begin
    cnt_d = cnt_q;
    if (tick_i) cnt_d = hit ? CNT_W'(1) : cnt_q + CNT_W'(1);
    if (cnt_wr_hi_i) cnt_d[CNT_W-1:8] = wdata_i[CNT_W-9:0];
    if (cnt_wr_lo_i) cnt_d[7:0] = wdata_i;

    cap_d = cap_q;
    if (cap_wr_hi_i) cap_d[CNT_W-1:8] = wdata_i[CNT_W-9:0];
    if (cap_wr_lo_i) cap_d[7:0] = wdata_i;
    if (cap_evt_i)   cap_d = cnt_q;

    flag_d = flag_q;
    if (hit)       flag_d = 1'b0;
    if (cap_evt_i) flag_d = 1'b1;

    irq_d = cap_evt_i | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      cap_q  <= '0;
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      cap_q  <= cap_d;
      flag_q <= flag_d;
      irq_q  <= irq_d;
    end
  end

  assign count_o      = cnt_q;
  assign capture_o    = cap_q;
  assign flag_o       = flag_q;
  assign irq_o        = irq_q;
  assign reload_evt_o = hit;
endmodule

// File: rtl/cap_timer.sv
module cap_timer #(
  parameter int CNT_W       = 16,
  parameter int PS_W        = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       tmr_in,
  output logic       irq
);
  import cap_timer_pkg::*;

  localparam logic [7:0] CTRL_MASK = 8'((1 << EN_BIT) | (1 << POL_BIT) | ((1 << PS_W) - 1));

  reg_addr_e        ra;
  logic [7:0]       ctrl_q, ctrl_d;
  logic [CNT_W-1:0] reload_q, reload_d;
  logic [7:0]       cnt_hold_q, cnt_hold_d;
  logic [7:0]       cap_hold_q, cap_hold_d;
  logic             run;
  logic             pol;
  logic [PS_W-1:0]  psel;
  logic             tick;
  logic             edge_raw;
  logic             cap_evt;
  logic             reload_evt;
  logic             stat_flag;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] capture;
  logic             wr_ctrl, wr_cnt_h, wr_cnt_l, wr_rld_h, wr_rld_l, wr_cap_h, wr_cap_l;

  assign ra   = reg_addr_e'(addr);
  assign run  = ctrl_q[EN_BIT];
  assign pol  = ctrl_q[POL_BIT];
  assign psel = ctrl_q[PS_W-1:0];

  assign wr_ctrl  = wr_en && (ra == A_CTRL);
  assign wr_cnt_h = wr_en && (ra == A_CNT_H);
  assign wr_cnt_l = wr_en && (ra == A_CNT_L);
  assign wr_rld_h = wr_en && (ra == A_RLD_H);
  assign wr_rld_l = wr_en && (ra == A_RLD_L);
  assign wr_cap_h = wr_en && (ra == A_CAP_H);
  assign wr_cap_l = wr_en && (ra == A_CAP_L);

  cap_timer_prescale #(.SEL_W(PS_W)) u_prescale (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (run),
    .sel_i  (psel),
    .tick_o (tick)
  );

  cap_timer_sync_edge #(.STAGES(SYNC_STAGES)) u_sync_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_i      (tmr_in),
    .fall_sel_i (pol),
    .edge_o     (edge_raw)
  );

  assign cap_evt = edge_raw & run;

  cap_timer_core #(.CNT_W(CNT_W)) u_core (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_i       (tick),
    .cap_evt_i    (cap_evt),
    .reload_i     (reload_q),
    .cnt_wr_hi_i  (wr_cnt_h),
    .cnt_wr_lo_i  (wr_cnt_l),
    .cap_wr_hi_i  (wr_cap_h),
    .cap_wr_lo_i  (wr_cap_l),
    .wdata_i      (wdata),
    .count_o      (count),
    .capture_o    (capture),
    .flag_o       (stat_flag),
    .irq_o        (irq),
    .reload_evt_o (reload_evt)
  );

  always_comb begin
    ctrl_d = wr_ctrl ? (wdata & CTRL_MASK) : ctrl_q;

    reload_d = reload_q;
    if (wr_rld_h) reload_d[CNT_W-1:8] = wdata[CNT_W-9:0];
    if (wr_rld_l) reload_d[7:0] = wdata;

    cnt_hold_d = (rd_en && ra == A_CNT_H) ? count[7:0]   : cnt_hold_q;
    cap_hold_d = (rd_en && ra == A_CAP_H) ? capture[7:0] : cap_hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      reload_q   <= '0;
      cnt_hold_q <= '0;
      cap_hold_q <= '0;
    end else begin
      ctrl_q     <= ctrl_d;
      reload_q   <= reload_d;
      cnt_hold_q <= cnt_hold_d;
      cap_hold_q <= cap_hold_d;
    end
  end

  always_comb begin
    unique case (ra)
      A_CTRL:  rdata = ctrl_q;
      A_STAT:  rdata = {7'b0, stat_flag};
      A_CNT_H: rdata = 8'(count[CNT_W-1:8]);
      A_CNT_L: rdata = cnt_hold_q;
      A_RLD_H: rdata = 8'(reload_q[CNT_W-1:8]);
      A_RLD_L: rdata = reload_q[7:0];
      A_CAP_H: rdata = 8'(capture[CNT_W-1:8]);
      A_CAP_L: rdata = cap_hold_q;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/cap_timer_chk.sv
module cap_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             tick,
  input logic             cap_evt,
  input logic             reload_evt,
  input logic             irq,
  input logic             stat_flag,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] reload_q,
  input logic [7:0]       cnt_hold_q,
  input logic             wr_en,
  input logic             rd_en,
  input logic [2:0]       addr
);
  import cap_timer_pkg::*;

  logic cnt_wr;
  assign cnt_wr = wr_en && (addr == A_CNT_H || addr == A_CNT_L);

  // R3
  reload_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && count == reload_q && !cnt_wr) |=> (count == CNT_W'(1)));

  // R3
  reload_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_evt && !cap_evt) |=> !stat_flag);

  // R4
  cap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> stat_flag);

  // R9
  irq_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt || reload_evt) |=> irq);

  // R9
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cap_evt || reload_evt) |=> !irq);

  // R5
  idle_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !irq);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_wr) |=> $stable(count));

  // R7
  hold_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_CNT_H) |=> (cnt_hold_q == $past(count[7:0])));
endmodule

bind cap_timer cap_timer_chk #(.CNT_W(CNT_W)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .run        (run),
  .tick       (tick),
  .cap_evt    (cap_evt),
  .reload_evt (reload_evt),
  .irq        (irq),
  .stat_flag  (stat_flag),
  .count      (count),
  .reload_q   (reload_q),
  .cnt_hold_q (cnt_hold_q),
  .wr_en      (wr_en),
  .rd_en      (rd_en),
  .addr       (addr)
);

// File: tb/test_cap_timer.sv
module test_cap_timer;
  logic       clk;
  logic       rst_n;
  logic       wr_en;
  logic       rd_en;
  logic [2:0] addr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       tmr_in;
  logic       irq;

  int n_checks;
  int n_fail;
  int irq_cnt;
  int irq_run;
  int irq_run_max;

  cap_timer i_cap_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .rd_en  (rd_en),
    .addr   (addr),
    .wdata  (wdata),
    .rdata  (rdata),
    .tmr_in (tmr_in),
    .irq    (irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(negedge clk) begin
    if (rst_n && irq) begin
      irq_cnt = irq_cnt + 1;
      irq_run = irq_run + 1;
      if (irq_run > irq_run_max) irq_run_max = irq_run;
    end else begin
      irq_run = 0;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wr16(input logic [2:0] hi_a, input logic [15:0] v);
    bus_wr(hi_a, v[15:8]);
    bus_wr(hi_a + 3'd1, v[7:0]);
  endtask

  task automatic rd16(input logic [2:0] hi_a, output logic [15:0] v);
    logic [7:0] h, l;
    bus_rd(hi_a, h);
    bus_rd(hi_a + 3'd1, l);
    v = {h, l};
  endtask

  task automatic t_reset;
    logic [7:0] d;
    for (int a = 0; a < 8; a++) begin
      bus_rd(3'(a), d);
      check("R1 register after reset", d, 8'h00);
    end
    check("R1 irq after reset", irq, 1'b0);
  endtask

  task automatic t_prescale;
    logic [15:0] v;
    logic [15:0] v2;
    wr16(3'd4, 16'hFFFF);
    wr16(3'd2, 16'h0001);
    bus_wr(3'd0, 8'h80);
    repeat (8) @(negedge clk);
    bus_wr(3'd0, 8'h00);
    rd16(3'd2, v);
    check("R2 divide by 1 count", v, 16'h000B);
    repeat (20) @(negedge clk);
    rd16(3'd2, v2);
    check("R2 hold while disabled", v2, v);
    wr16(3'd2, 16'h0001);
    bus_wr(3'd0, 8'h84);
    repeat (78) @(negedge clk);
    bus_wr(3'd0, 8'h04);
    rd16(3'd2, v);
    check("R2 divide by 16 count", v, 16'h0006);
  endtask

  task automatic t_cap_rise;
    logic [15:0] v;
    logic [7:0]  s;
    int base;
    wr16(3'd2, 16'h1234);
    wr16(3'd6, 16'h0000);
    base = irq_cnt;
    bus_wr(3'd0, 8'h87);
    repeat (5) @(negedge clk);
    tmr_in = 1'b1;
    repeat (10) @(negedge clk);
    rd16(3'd6, v);
    check("R4 rising capture value", v, 16'h1234);
    bus_rd(3'd1, s);
    check("R4 capture flag set", s, 8'h01);
    check("R4 one irq on capture", irq_cnt - base, 1);
    tmr_in = 1'b0;
    repeat (10) @(negedge clk);
    check("R5 falling edge ignored irq", irq_cnt - base, 1);
    repeat (110) @(negedge clk);
    rd16(3'd2, v);
    check("R4 counter kept running", v, 16'h1235);
    rd16(3'd6, v);
    check("R5 falling edge ignored capture", v, 16'h1234);
    bus_wr(3'd0, 8'h07);
  endtask

  task automatic t_cap_fall;
    logic [15:0] v;
    int base;
    wr16(3'd2, 16'h0ABC);
    bus_wr(3'd0, 8'hC7);
    base = irq_cnt;
    repeat (3) @(negedge clk);
    tmr_in = 1'b1;
    repeat (8) @(negedge clk);
    rd16(3'd6, v);
    check("R5 rising ignored in falling mode", v, 16'h1234);
    tmr_in = 1'b0;
    repeat (8) @(negedge clk);
    rd16(3'd6, v);
    check("R4 falling capture value", v, 16'h0ABC);
    check("R4 one irq on falling capture", irq_cnt - base, 1);
    bus_wr(3'd0, 8'h47);
    base = irq_cnt;
    tmr_in = 1'b1;
    repeat (6) @(negedge clk);
    tmr_in = 1'b0;
    repeat (6) @(negedge clk);
    rd16(3'd6, v);
    check("R5 edges while disabled capture", v, 16'h0ABC);
    check("R5 edges while disabled irq", irq_cnt - base, 0);
  endtask

  task automatic t_reload;
    logic [15:0] v;
    logic [7:0]  s;
    int base;
    wr16(3'd6, 16'h0000);
    wr16(3'd4, 16'h0005);
    wr16(3'd2, 16'h0003);
    base = irq_cnt;
    irq_run_max = 0;
    bus_wr(3'd0, 8'h80);
    repeat (4) @(negedge clk);
    bus_wr(3'd0, 8'h00);
    repeat (3) @(negedge clk);
    rd16(3'd2, v);
    check("R3 count after wrap", v, 16'h0004);
    check("R3 one irq on reload", irq_cnt - base, 1);
    check("R9 irq one cycle wide", irq_run_max, 1);
    bus_rd(3'd1, s);
    check("R3 flag cleared by reload", s, 8'h00);
    rd16(3'd6, v);
    check("R8 cleared capture stays zero", v, 16'h0000);
  endtask

  task automatic t_simul;
    logic [15:0] v;
    logic [7:0]  s;
    int base;
    wr16(3'd4, 16'h0040);
    wr16(3'd2, 16'h0040);
    base = irq_cnt;
    bus_wr(3'd0, 8'h87);
    repeat (125) @(negedge clk);
    tmr_in = 1'b1;
    repeat (5) @(negedge clk);
    bus_wr(3'd0, 8'h07);
    repeat (3) @(negedge clk);
    rd16(3'd6, v);
    check("R6 capture takes pre-wrap count", v, 16'h0040);
    rd16(3'd2, v);
    check("R6 counter wrapped", v, 16'h0001);
    bus_rd(3'd1, s);
    check("R6 capture wins flag", s, 8'h01);
    check("R6 single irq", irq_cnt - base, 1);
    tmr_in = 1'b0;
  endtask

  task automatic t_coherent;
    logic [7:0] d;
    wr16(3'd2, 16'h1234);
    bus_rd(3'd2, d);
    check("R7 high byte", d, 8'h12);
    bus_wr(3'd3, 8'h56);
    bus_rd(3'd3, d);
    check("R7 low from holding", d, 8'h34);
    bus_rd(3'd2, d);
    bus_rd(3'd3, d);
    check("R7 holding refreshed", d, 8'h56);
    wr16(3'd4, 16'hFFFF);
    wr16(3'd2, 16'h00FD);
    bus_wr(3'd0, 8'h80);
    bus_rd(3'd2, d);
    check("R7 running high byte", d, 8'h00);
    repeat (5) @(negedge clk);
    bus_rd(3'd3, d);
    check("R7 running low frozen", d, 8'hFE);
    bus_wr(3'd0, 8'h00);
  endtask

  task automatic t_regs;
    logic [7:0]  s;
    logic [15:0] v;
    bus_wr(3'd1, 8'h00);
    bus_rd(3'd1, s);
    check("R8 status write ignored", s, 8'h01);
    wr16(3'd4, 16'hBEEF);
    bus_rd(3'd4, v[15:8]);
    bus_rd(3'd5, v[7:0]);
    check("R8 reload readback", v, 16'hBEEF);
    bus_wr(3'd0, 8'hFF);
    bus_rd(3'd0, s);
    check("R8 control unused bits", s, 8'hC7);
    bus_wr(3'd0, 8'h00);
  endtask

  initial begin
    n_checks = 0; n_fail = 0; irq_cnt = 0; irq_run = 0; irq_run_max = 0;
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0; tmr_in = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_prescale();
    t_cap_rise();
    t_cap_fall();
    t_reload();
    t_simul();
    t_coherent();
    t_regs();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #400000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule